// File: doc/BRIEF.md
# Line-Gated SDRAM Write Sequencer

This block takes a pixel stream arriving one line at a time and stores each line in a single SDRAM bank. Every line becomes one full-page burst: one row activation, one write command at column zero, and then one data beat per incoming pixel. After the last pixel it closes the row with a precharge of all banks. The idle gap that the camera leaves between lines is then filled with a fixed budget of auto-refresh commands. The refresh work therefore never competes with pixel capture, and no periodic refresh timer is needed.

A refresh row pointer carries over from one gap to the next and wraps at the last row, so the whole device is refreshed in a steady sweep. A one-cycle flag marks the end of each sweep. The write row pointer moves forward by one row per stored line and is exported as a written-line count to the buffer-swap logic next to the block. A swap request from that logic returns the pointer to row zero. Commands reach the memory through an abstract port that carries a command code, a row, a column, the write data and a data-enable strobe. Power-up initialisation and electrical timing are handled outside the block.

Top module: `line_sdram_writer`

## Requirements
- R1: While reset is low and on the first cycle after it, `sd_cmd` is NOP (0), `sd_wen` is 0, `rows_written` is 0 and `sweep_done` is 0.
- R2: Until a `start` pulse has been sampled, the block issues no command and no data beat, whatever `line_sync` and `pix_valid` do.
- R3: When `line_sync` is sampled in the idle gap with no refresh in progress, ACTIVATE (1) appears on `sd_cmd` in the next cycle, and `sd_row` equals `rows_written`.
- R4: The first `pix_valid` after the activation produces WRITE (2) with `sd_col` 0, `sd_wen` 1 and that pixel on `sd_wdata`, one cycle later. Each later pixel of the line appears one cycle after it is sampled, with `sd_wen` 1 and NOP on `sd_cmd`.
- R5: When the line's last pixel has been streamed (PIX_PER_LINE beats), the next cycle carries PRECHARGE (3), meaning all banks. In that same cycle `rows_written` advances by one, modulo ROWS.
- R6: The first REFRESH (4) of a gap comes exactly PRE_CLKS cycles after the PRECHARGE, and each further one comes REF_CLKS cycles after the previous one. A gap holds at most REF_PER_GAP refreshes.
- R7: `sd_row` on each REFRESH is a refresh pointer. The pointer steps by one per refresh, carries across gaps and wraps from ROWS-1 to 0.
- R8: `sweep_done` is a one-cycle pulse. It is high exactly in the cycle that carries the REFRESH for row ROWS-1.
- R9: A sync that arrives while a precharge or refresh window is still open is held. No further refresh starts. ACTIVATE appears in the cycle right after that window ends, which is the first cycle at or after the sync in which a new refresh could have started. A sync sampled in that same cycle wins over a refresh.
- R10: A `buf_swap` pulse in the gap sets `rows_written` to 0 in the next cycle. A pulse during a line is held, and at the line's PRECHARGE `rows_written` becomes 0 instead of advancing.
- R11: `pix_valid` in the gap between lines produces no data beat and no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that enables the sequencer |
| line_sync | input | 1 | One-cycle pulse ahead of each line |
| pix_valid | input | 1 | Pixel present on `pix_data` |
| pix_data | input | DATA_W | Pixel value |
| buf_swap | input | 1 | Swap request from the buffer-swap logic |
| sd_cmd | output | 3 | Command: 0 NOP, 1 ACTIVATE, 2 WRITE, 3 PRECHARGE all, 4 REFRESH |
| sd_row | output | log2(ROWS) | Row for ACTIVATE, refresh pointer for REFRESH |
| sd_col | output | log2(PIX_PER_LINE) | Start column for WRITE |
| sd_wdata | output | DATA_W | Write data beat |
| sd_wen | output | 1 | Write data beat valid |
| rows_written | output | log2(ROWS) | Lines stored since the last swap |
| sweep_done | output | 1 | Pulse on the refresh of the last row |

## Verification
The bench varies the gap length so that the refresh budget is sometimes used up, sometimes cut short, and once not reached at all. One sync lands in the very cycle a refresh would otherwise have started. A design that put refresh ahead of sync, or that started refreshes after a pending sync, would show a late ACTIVATE or extra REFRESH commands. Enough gaps are run for the refresh pointer to wrap. A pointer reset per gap, or a sweep flag off by one row, shows up as wrong `sd_row` values or a misplaced pulse. Swaps are issued both in the gap and in the middle of a line. A design that applied a mid-line swap at once, or let the increment override it, would report a wrong written-line count. Stray syncs and pixels are sent before start and during the gap to expose any leakage of commands or data beats.

// File: rtl/wsq_pkg.sv
// Shared types of the line-gated SDRAM write sequencer.
// Assumes: the command codes below are what the memory-side adapter decodes.
package wsq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_ACT   = 3'd1,
        CMD_WRITE = 3'd2,
        CMD_PRE   = 3'd3,
        CMD_REF   = 3'd4
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_OPEN,
        ST_BURST,
        ST_CLOSE,
        ST_WAIT
    } wsq_state_e;

endpackage

// File: rtl/wsq_refresh.sv
// Refresh bookkeeping: the per-gap budget and the rotating refresh row pointer.
// Assumes: load and issue never occur in the same cycle (the controller
// only issues refreshes from its idle state, never while closing a line).
module wsq_refresh #(
    parameter int ROWS   = 4096,
    parameter int BUDGET = 20,
    localparam int ROW_W = $clog2(ROWS),
    localparam int CNT_W = $clog2(BUDGET + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             issue,
    output logic             avail,
    output logic [ROW_W-1:0] ref_row,
    output logic             sweep
);

    logic [CNT_W-1:0] left;

    // Refill the budget at each line end, then spend it one refresh at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left <= '0;
        end else if (load) begin
            left <= CNT_W'(BUDGET);
        end else if (issue && left != '0) begin
            left <= left - 1'b1;
        end
    end

    // Step the row pointer on each refresh, wrap it and flag the last row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_row <= '0;
            sweep   <= 1'b0;
        end else begin
            sweep <= 1'b0;
            if (issue) begin
                if (ref_row == ROW_W'(ROWS - 1)) begin
                    ref_row <= '0;
                    sweep   <= 1'b1;
                end else begin
                    ref_row <= ref_row + 1'b1;
                end
            end
        end
    end

    assign avail = (left != '0);

endmodule

// File: rtl/wsq_rowptr.sv
// Write row pointer: one row per stored line, cleared by a buffer swap.
// Assumes: in_line covers the whole span from the activation decision up to
// and including the precharge cycle, so a swap is never lost inside a line.
module wsq_rowptr #(
    parameter int ROWS = 4096,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             swap,
    input  logic             in_line,
    input  logic             line_done,
    output logic [ROW_W-1:0] wr_row
);

    logic pend;

    // Advance at line end; apply a swap now in the gap or defer it to line end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_row <= '0;
            pend   <= 1'b0;
        end else if (line_done) begin
            pend   <= 1'b0;
            if (pend || swap)
                wr_row <= '0;
            else if (wr_row == ROW_W'(ROWS - 1))
                wr_row <= '0;
            else
                wr_row <= wr_row + 1'b1;
        end else if (swap) begin
            if (in_line)
                pend <= 1'b1;
            else
                wr_row <= '0;
        end
    end

endmodule

// File: rtl/wsq_ctrl.sv
// Moore controller: opens a row per line, streams the full-page burst,
// closes it, then runs refreshes in the gap until the next sync.
// Assumes: pixels of a line are sampled no earlier than the row-to-column delay
// after the activation, and the memory closes a full-page burst on precharge.
module wsq_ctrl #(
    parameter int PIX_PER_LINE = 1024,
    parameter int DATA_W       = 16,
    parameter int ROW_W        = 12,
    parameter int PRE_CLKS     = 2,
    parameter int REF_CLKS     = 8,
    localparam int COL_W = $clog2(PIX_PER_LINE),
    localparam int WT_W  = $clog2(PRE_CLKS + REF_CLKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              line_sync,
    input  logic              pix_valid,
    input  logic [DATA_W-1:0] pix_data,
    input  logic              ref_avail,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [ROW_W-1:0]  ref_row,
    output logic              ref_issue,
    output logic              line_done,
    output logic              in_line,
    output logic [2:0]        cmd_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W-1:0]  col_o,
    output logic [DATA_W-1:0] data_o,
    output logic              we_o
);
    import wsq_pkg::*;

    wsq_state_e       state;
    logic [WT_W-1:0]  wait_cnt;
    logic [COL_W-1:0] beat;
    logic             sync_pend;
    logic             go_act;
    logic             go_ref;

    // Decide in the idle state: a sync (new or held) wins over a refresh.
    always_comb begin
        go_act    = (state == ST_IDLE) && (line_sync || sync_pend);
        go_ref    = (state == ST_IDLE) && !go_act && ref_avail;
        ref_issue = go_ref;
        line_done = (state == ST_CLOSE);
        in_line   = go_act || (state == ST_OPEN) || (state == ST_BURST)
                    || (state == ST_CLOSE);
    end

    // State register, timers and the registered command port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_OFF;
            wait_cnt  <= '0;
            beat      <= '0;
            sync_pend <= 1'b0;
            cmd_o     <= CMD_NOP;
            row_o     <= '0;
            col_o     <= '0;
            data_o    <= '0;
            we_o      <= 1'b0;
        end else begin
            cmd_o <= CMD_NOP;
            row_o <= '0;
            col_o <= '0;
            we_o  <= 1'b0;
            case (state)
                ST_OFF: begin
                    if (start)
                        state <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (go_act) begin
                        cmd_o     <= CMD_ACT;
                        row_o     <= wr_row;
                        sync_pend <= 1'b0;
                        state     <= ST_OPEN;
                    end else if (go_ref) begin
                        cmd_o    <= CMD_REF;
                        row_o    <= ref_row;
                        wait_cnt <= WT_W'(REF_CLKS - 2);
                        state    <= ST_WAIT;
                    end
                end
                ST_OPEN: begin
                    if (pix_valid) begin
                        cmd_o  <= CMD_WRITE;
                        col_o  <= '0;
                        data_o <= pix_data;
                        we_o   <= 1'b1;
                        beat   <= COL_W'(1);
                        state  <= ST_BURST;
                    end
                end
                ST_BURST: begin
                    if (pix_valid) begin
                        data_o <= pix_data;
                        we_o   <= 1'b1;
                        beat   <= beat + 1'b1;
                        if (beat == COL_W'(PIX_PER_LINE - 1))
                            state <= ST_CLOSE;
                    end
                end
                ST_CLOSE: begin
                    cmd_o    <= CMD_PRE;
                    wait_cnt <= WT_W'(PRE_CLKS - 2);
                    state    <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (line_sync)
                        sync_pend <= 1'b1;
                    if (wait_cnt == '0)
                        state <= ST_IDLE;
                    else
                        wait_cnt <= wait_cnt - 1'b1;
                end
                default: state <= ST_OFF;
            endcase
        end
    end

endmodule

// File: rtl/line_sdram_writer.sv
// Top of the line-gated SDRAM write sequencer: writes each pixel line as one
// full-page burst into one bank and refreshes during the gaps between lines.
// Assumes: PIX_PER_LINE and ROWS are powers of two, PRE_CLKS and REF_CLKS >= 2,
// and REF_PER_GAP refreshes plus the precharge fit inside the camera's gap.
module line_sdram_writer #(
    parameter int PIX_PER_LINE = 1024,
    parameter int DATA_W       = 16,
    parameter int ROWS         = 4096,
    parameter int REF_PER_GAP  = 20,
    parameter int REF_CLKS     = 8,
    parameter int PRE_CLKS     = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic                             line_sync,
    input  logic                             pix_valid,
    input  logic [DATA_W-1:0]                pix_data,
    input  logic                             buf_swap,
    output logic [2:0]                       sd_cmd,
    output logic [$clog2(ROWS)-1:0]          sd_row,
    output logic [$clog2(PIX_PER_LINE)-1:0]  sd_col,
    output logic [DATA_W-1:0]                sd_wdata,
    output logic                             sd_wen,
    output logic [$clog2(ROWS)-1:0]          rows_written,
    output logic                             sweep_done
);
    localparam int ROW_W = $clog2(ROWS);

    logic             ref_avail;
    logic             ref_issue;
    logic             line_done;
    logic             in_line;
    logic [ROW_W-1:0] wr_row;
    logic [ROW_W-1:0] ref_row;

    wsq_ctrl #(
        .PIX_PER_LINE(PIX_PER_LINE),
        .DATA_W      (DATA_W),
        .ROW_W       (ROW_W),
        .PRE_CLKS    (PRE_CLKS),
        .REF_CLKS    (REF_CLKS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .line_sync(line_sync),
        .pix_valid(pix_valid),
        .pix_data (pix_data),
        .ref_avail(ref_avail),
        .wr_row   (wr_row),
        .ref_row  (ref_row),
        .ref_issue(ref_issue),
        .line_done(line_done),
        .in_line  (in_line),
        .cmd_o    (sd_cmd),
        .row_o    (sd_row),
        .col_o    (sd_col),
        .data_o   (sd_wdata),
        .we_o     (sd_wen)
    );

    wsq_refresh #(
        .ROWS  (ROWS),
        .BUDGET(REF_PER_GAP)
    ) u_refresh (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (line_done),
        .issue  (ref_issue),
        .avail  (ref_avail),
        .ref_row(ref_row),
        .sweep  (sweep_done)
    );

    wsq_rowptr #(
        .ROWS(ROWS)
    ) u_rowptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .swap     (buf_swap),
        .in_line  (in_line),
        .line_done(line_done),
        .wr_row   (wr_row)
    );

    assign rows_written = wr_row;

endmodule

// File: rtl/wsq_checker.sv
// Port-level properties of the write sequencer, attached by bind.
module wsq_checker #(
    parameter int ROWS  = 4096,
    parameter int ROW_W = 12,
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       sd_cmd,
    input logic [ROW_W-1:0] sd_row,
    input logic [COL_W-1:0] sd_col,
    input logic             sd_wen,
    input logic [ROW_W-1:0] rows_written,
    input logic             sweep_done
);

    // R3: an activation targets the current write row
    a_r3_act_row: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == 3'd1) |-> (sd_row == rows_written));

    // R4: the write command starts at column 0 and carries data
    a_r4_write_col0: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == 3'd2) |-> (sd_wen && sd_col == '0));

    // R4: later beats of the burst travel with NOP
    a_r4_quiet_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_wen && sd_cmd != 3'd2) |-> (sd_cmd == 3'd0));

    // R5: a precharge directly follows a data beat
    a_r5_close_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == 3'd3) |-> $past(sd_wen));

    // R6: a refresh is followed by at least one idle command cycle
    a_r6_ref_then_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == 3'd4) |=> (sd_cmd == 3'd0));

    // R8: the sweep flag marks the refresh of the last row
    a_r8_sweep_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |-> (sd_cmd == 3'd4 && sd_row == ROW_W'(ROWS - 1)));

    // R8: the sweep flag lasts one cycle
    a_r8_sweep_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |=> !sweep_done);

endmodule

bind line_sdram_writer wsq_checker #(
    .ROWS (ROWS),
    .ROW_W($clog2(ROWS)),
    .COL_W($clog2(PIX_PER_LINE))
) u_wsq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .sd_cmd      (sd_cmd),
    .sd_row      (sd_row),
    .sd_col      (sd_col),
    .sd_wen      (sd_wen),
    .rows_written(rows_written),
    .sweep_done  (sweep_done)
);

// File: tb/line_sdram_writer_test.sv
module line_sdram_writer_test;

    localparam int PIX    = 16;
    localparam int DW     = 16;
    localparam int ROWS   = 32;
    localparam int BUDGET = 4;
    localparam int REFC   = 8;
    localparam int PREC   = 3;
    localparam int LEAD   = 2;
    localparam int ROW_W  = $clog2(ROWS);
    localparam int COL_W  = $clog2(PIX);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic line_sync = 1'b0;
    logic pix_valid = 1'b0;
    logic [DW-1:0] pix_data = '0;
    logic buf_swap = 1'b0;
    logic [2:0] sd_cmd;
    logic [ROW_W-1:0] sd_row;
    logic [COL_W-1:0] sd_col;
    logic [DW-1:0] sd_wdata;
    logic sd_wen;
    logic [ROW_W-1:0] rows_written;
    logic sweep_done;

    line_sdram_writer #(
        .PIX_PER_LINE(PIX), .DATA_W(DW), .ROWS(ROWS),
        .REF_PER_GAP(BUDGET), .REF_CLKS(REFC), .PRE_CLKS(PREC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .line_sync(line_sync),
        .pix_valid(pix_valid), .pix_data(pix_data), .buf_swap(buf_swap),
        .sd_cmd(sd_cmd), .sd_row(sd_row), .sd_col(sd_col),
        .sd_wdata(sd_wdata), .sd_wen(sd_wen),
        .rows_written(rows_written), .sweep_done(sweep_done)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int cyc; int cmd; int row; int col; int data; bit we; bit sw; int tag;
    } ev_t;
    ev_t exp_q[$];

    int n_chk = 0;
    int n_fail = 0;
    int obs_n = 0;
    int unexp_tag = 2;
    bit finished = 1'b0;

    function automatic string tname(input int t);
        case (t)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            10: return "R10"; default: return "R11";
        endcase
    endfunction

    task automatic chk(input bit ok, input int tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d",
                     tname(tag), what, act, exp, cyc);
        end
    endtask

    function automatic void push(input int c, input int cmd, input int row,
                                 input int col, input int data, input bit we,
                                 input bit sw, input int tag);
        ev_t e;
        e.cyc = c; e.cmd = cmd; e.row = row; e.col = col;
        e.data = data; e.we = we; e.sw = sw; e.tag = tag;
        exp_q.push_back(e);
    endfunction

    // Monitor: pop each expected event as the design produces it.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (sd_cmd != 3'd0 || sd_wen) begin
                obs_n++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, unexp_tag, "unexpected command/beat", int'(sd_cmd), 0);
                end else begin
                    ev_t e;
                    e = exp_q.pop_front();
                    chk(cyc == e.cyc, (e.cmd == 4) ? 6 : e.tag, "event cycle", cyc, e.cyc);
                    chk(int'(sd_cmd) == e.cmd, e.tag, "command", int'(sd_cmd), e.cmd);
                    chk(sd_wen == e.we, 4, "data enable", int'(sd_wen), int'(e.we));
                    if (e.cmd == 1)
                        chk(int'(sd_row) == e.row, 3, "activate row", int'(sd_row), e.row);
                    if (e.cmd == 4)
                        chk(int'(sd_row) == e.row, 7, "refresh row", int'(sd_row), e.row);
                    if (e.cmd == 2)
                        chk(int'(sd_col) == 0, 4, "write column", int'(sd_col), 0);
                    if (e.we)
                        chk(int'(sd_wdata) == e.data, 4, "write data", int'(sd_wdata), e.data);
                    chk(sweep_done == e.sw, 8, "sweep flag", int'(sweep_done), int'(e.sw));
                end
            end else if (sweep_done) begin
                chk(1'b0, 8, "sweep flag without refresh", 1, 0);
            end
        end
    end

    task automatic wait_until(input int e);
        while (cyc + 1 < e) @(negedge clk);
    endtask

    int m_row = 0;
    int m_ref = 0;
    int act_e = 0;
    int act_tag = 3;
    int s_next = 0;
    int line_no = 0;

    // Driver: predict one line plus the following gap, then drive it.
    task automatic send_line(input int nxt_delay, input int swap_beat, input bit gap_swap);
        int s_cur, f, p, s, n, row_after;
        s_cur = s_next;
        if (gap_swap) begin
            wait_until(s_cur - 4);
            buf_swap = 1'b1;
            @(negedge clk);
            buf_swap = 1'b0;
            chk(rows_written == '0, 10, "rows_written after gap swap", int'(rows_written), 0);
            m_row = 0;
            pix_valid = 1'b1;
            pix_data = 16'hDEAD;
            @(negedge clk);
            pix_valid = 1'b0;
            chk(!sd_wen && sd_cmd == 3'd0, 11, "beat from gap pixel", int'(sd_wen), 0);
        end
        push(act_e, 1, m_row, 0, 0, 1'b0, 1'b0, act_tag);
        f = act_e + LEAD;
        for (int i = 0; i < PIX; i++)
            push(f + i, (i == 0) ? 2 : 0, 0, 0, (line_no * 53 + i * 7 + 1) & 16'hFFFF,
                 1'b1, 1'b0, 4);
        p = f + PIX;
        push(p, 3, 0, 0, 0, 1'b0, 1'b0, 5);
        row_after = (swap_beat >= 0) ? 0 : (m_row + 1) % ROWS;
        if (nxt_delay < 0) begin
            s = 32'h7FFF_FFFF;
            n = BUDGET;
        end else begin
            s = p + nxt_delay;
            n = 0;
            for (int k = 0; k < BUDGET; k++)
                if (p + PREC + k * REFC < s) n++;
        end
        for (int k = 0; k < n; k++) begin
            push(p + PREC + k * REFC, 4, m_ref, 0, 0, 1'b0, m_ref == ROWS - 1, 6);
            m_ref = (m_ref + 1) % ROWS;
        end
        // sync drive
        wait_until(s_cur);
        line_sync = 1'b1;
        @(negedge clk);
        line_sync = 1'b0;
        for (int i = 0; i < PIX; i++) begin
            wait_until(f + i);
            pix_valid = 1'b1;
            pix_data = DW'((line_no * 53 + i * 7 + 1) & 16'hFFFF);
            buf_swap = (i == swap_beat);
        end
        @(negedge clk);
        pix_valid = 1'b0;
        buf_swap = 1'b0;
        if (swap_beat >= 0)
            chk(int'(rows_written) == m_row, 10, "rows_written held during line",
                int'(rows_written), m_row);
        while (cyc < p) @(negedge clk);
        m_row = row_after;
        chk(int'(rows_written) == m_row, (swap_beat >= 0) ? 10 : 5,
            "rows_written at precharge", int'(rows_written), m_row);
        s_next = s;
        act_e = (s > p + PREC + n * REFC) ? s : p + PREC + n * REFC;
        act_tag = (nxt_delay >= 0 && n < BUDGET) ? 9 : 3;
        line_no++;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, 11, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sd_cmd == 3'd0 && !sd_wen, 1, "command in reset", int'(sd_cmd), 0);
        chk(rows_written == '0 && !sweep_done, 1, "counters in reset", int'(rows_written), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sd_cmd == 3'd0 && !sd_wen && rows_written == '0 && !sweep_done, 1,
            "state after reset", int'(sd_cmd), 0);
        // R2 stimulus before start
        unexp_tag = 2;
        line_sync = 1'b1;
        @(negedge clk);
        line_sync = 1'b0;
        for (int i = 0; i < 6; i++) begin
            pix_valid = 1'b1;
            pix_data = DW'(i + 5);
            @(negedge clk);
        end
        pix_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(obs_n == 0, 2, "events before start", obs_n, 0);
        unexp_tag = 11;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        s_next = cyc + 3;
        act_e = s_next;
        act_tag = 3;
        send_line(60, -1, 1'b0);
        send_line(12, -1, 1'b0);
        send_line(19, 5, 1'b0);
        send_line(2, -1, 1'b0);
        send_line(40, -1, 1'b0);
        send_line(36, -1, 1'b1);
        for (int l = 0; l < 5; l++) send_line(36, -1, 1'b0);
        send_line(-1, -1, 1'b0);
        repeat (PREC + BUDGET * REFC + 10) @(negedge clk);
        chk(exp_q.size() == 0, 6, "expected events left over", exp_q.size(), 0);
        finish_run();
    end

endmodule